// File: doc/BRIEF.md
# E1 Spare-Bit Multiframe Access

This block gives a host register access to the five national spare bits, Sa4 to Sa8, that travel in the timeslot 0 service words of an E1 CRC multiframe. An external framer supplies the frame timing and the received timeslot 0 byte. Only every other frame carries a service word, so a multiframe holds eight service words. On receive, the block gathers each Sa bit position across those eight service words into one byte register per Sa bit. On transmit, it takes bytes written by the host and places them bit by bit into the outgoing service words.

Transmit data is double buffered. The host writes a working bank. At each multiframe start, that bank is copied into a shadow bank, and the line is driven only from the shadow bank. A multiframe that the host does not refresh is therefore sent again unchanged. Two sticky flags mark the receive and transmit multiframe starts, and the host clears them with an acknowledge pulse.

When multiframe mode is off, the block uses a simpler per-frame scheme instead. One receive register and one transmit register cover single service words.

Top module: `sa_access`

## Requirements
- R1: In multiframe mode, the k-th service-word frame after a multiframe-start frame (k counts from 0 to 7) supplies bit k of each receive Sa register. Sa4 is taken from timeslot 0 byte bit 4, Sa5 from bit 3, Sa6 from bit 2, Sa7 from bit 1 and Sa8 from bit 0.
- R2: The five receive Sa registers all load together at a multiframe-start strobe in multiframe mode, taking the values collected in the multiframe just completed. Between such strobes they hold their values. They are read with rd_sel_i set to 0 to 4, in the order Sa4 to Sa8.
- R3: The receive flag rx_mb_irq_o sets at each multiframe-start strobe in multiframe mode. It stays set until irq_ack_i[0] is pulsed. When a set and an acknowledge fall in the same cycle, the set wins.
- R4: At each multiframe-start strobe in multiframe mode, the working transmit registers are copied into the shadow bank. At the same strobe, tx_mb_irq_o sets; it is cleared by irq_ack_i[1], and a set in the same cycle wins.
- R5: In multiframe mode, during the k-th service-word strobe, tx_ts0_o bits 4..0 carry bit k of the shadow Sa4..Sa8 registers, using the R1 bit positions. Bits 7..5 pass through from tx_ts0_i.
- R6: If the host writes nothing before the next multiframe start, the same shadow contents are sent again in the next multiframe.
- R7: A host write with wr_sel_i set to 0 to 4 updates the working Sa4..Sa8 register at once, and the new value reads back at rd_sel_i 8 to 12. The line keeps sending the old shadow contents until the next multiframe start.
- R8: While ts0_transp_i is high, tx_ts0_o equals tx_ts0_i.
- R9: Outside a service-word strobe, tx_ts0_o equals tx_ts0_i. A service-word strobe means frame_stb_i and svc_word_i are high and mf_start_i is low.
- R10: With mf_mode_i low, the following hold:
  - each service-word strobe captures the whole received byte into a register read at rd_sel_i 5;
  - a transmit register, written with wr_sel_i 5 and read at rd_sel_i 13, supplies bits 4..0 of every service word;
  - multiframe starts set no flag and change no receive Sa register.
- R11: After reset, every register reads zero and both flags are clear. A rd_sel_i value with no register assigned to it (6, 7, 14, 15) reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_stb_i | input | 1 | One-cycle strobe per frame while the timeslot 0 bytes are valid |
| svc_word_i | input | 1 | The current frame carries a service word |
| mf_start_i | input | 1 | The current frame is the first frame of a multiframe |
| mf_mode_i | input | 1 | 1: multiframe register mode, 0: per-frame mode |
| ts0_transp_i | input | 1 | Timeslot 0 transparent mode; suppresses insertion |
| rx_ts0_i | input | 8 | Received timeslot 0 byte |
| tx_ts0_i | input | 8 | Outgoing timeslot 0 byte before insertion |
| tx_ts0_o | output | 8 | Outgoing timeslot 0 byte after insertion |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 3 | Write select: 0-4 Sa4..Sa8 working register, 5 per-frame register |
| wr_data_i | input | 8 | Host write data |
| rd_sel_i | input | 4 | Read select: 0-4 rx Sa, 5 rx per-frame, 8-12 tx working Sa, 13 tx per-frame |
| rd_data_o | output | 8 | Read data |
| irq_ack_i | input | 2 | Flag acknowledge: bit 0 receive, bit 1 transmit |
| rx_mb_irq_o | output | 1 | Receive multiframe-start flag |
| tx_mb_irq_o | output | 1 | Transmit multiframe-start flag |

## Verification
The assertions check the following on every cycle:
- the flag behaviour (set, hold, clear, and set winning over acknowledge);
- that the receive Sa registers hold between multiframe starts;
- that the output passes through outside service-word strobes, under transparent mode and on the upper three bits.

The bench scenarios are needed for the rest. They show the exact bit placement of each service word in the receive and shadow banks, the one-multiframe delay of a host write before it reaches the line, and the repeat of an unrefreshed multiframe. They also cover the whole per-frame mode.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int SA_NUM    = 5;  // Sa4..Sa8
  localparam int SW_PER_MF = 8;  // service words per multiframe
  localparam int BYTE_W    = 8;
  localparam int RD_W      = 4;
  localparam int WR_W      = 3;
  localparam int SEL_SW    = 5;  // per-frame register select
  localparam int RD_TX_OFS = 8;  // tx working bank read offset
  localparam int RD_TX_SW  = 13;
endpackage

// File: rtl/sa_rx_capture.sv
module sa_rx_capture #(
  parameter int SA_NUM = 5,
  parameter int SW     = 8,
  parameter int BYTE_W = 8,
  localparam int IDX_W = (SW > 1) ? $clog2(SW) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_en_i,
  input  logic              commit_i,
  input  logic              sw_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [SW-1:0]     sa_o [SA_NUM],
  output logic [BYTE_W-1:0] sw_o
);
  logic [SW-1:0] coll_q [SA_NUM];

  for (genvar j = 0; j < SA_NUM; j++) begin : g_sa
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        coll_q[j] <= '0;
        sa_o[j]   <= '0;
      end else begin
        if (cap_en_i) coll_q[j][idx_i] <= byte_i[SA_NUM-1-j];
        if (commit_i) sa_o[j] <= coll_q[j];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sw_o <= '0;
    else if (sw_en_i) sw_o <= byte_i;
  end
endmodule

// File: rtl/sa_tx_insert.sv
module sa_tx_insert #(
  parameter int SA_NUM = 5,
  parameter int SW     = 8,
  parameter int BYTE_W = 8,
  parameter int WR_W   = 3,
  parameter int SEL_SW = 5,
  localparam int IDX_W = (SW > 1) ? $clog2(SW) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WR_W-1:0]   wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              load_i,
  input  logic              ins_en_i,
  input  logic              mf_mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic [SW-1:0]     work_o [SA_NUM],
  output logic [BYTE_W-1:0] sw_o
);
  logic [SW-1:0] shad_q [SA_NUM];

  for (genvar j = 0; j < SA_NUM; j++) begin : g_sa
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        work_o[j] <= '0;
        shad_q[j] <= '0;
      end else begin
        if (wr_en_i && wr_sel_i == WR_W'(j)) work_o[j] <= wr_data_i[SW-1:0];
        if (load_i) shad_q[j] <= work_o[j];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sw_o <= '0;
    else if (wr_en_i && wr_sel_i == WR_W'(SEL_SW)) sw_o <= wr_data_i;
  end

  always_comb begin
    byte_o = byte_i;
    if (ins_en_i) begin
      for (int j = 0; j < SA_NUM; j++) begin
        byte_o[SA_NUM-1-j] = mf_mode_i ? shad_q[j][idx_i] : sw_o[SA_NUM-1-j];
      end
    end
  end
endmodule

// File: rtl/sa_irq_flags.sv
module sa_irq_flags #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[i] <= 1'b0;
      else if (set_i[i]) flag_o[i] <= 1'b1;  // set wins over ack
      else if (ack_i[i]) flag_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sa_access.sv
module sa_access
  import sa_pkg::*;
#(
  parameter int N_SA  = SA_NUM,
  parameter int N_SW  = SW_PER_MF,
  parameter int DW    = BYTE_W,
  localparam int IDX_W = (N_SW > 1) ? $clog2(N_SW) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_stb_i,
  input  logic          svc_word_i,
  input  logic          mf_start_i,
  input  logic          mf_mode_i,
  input  logic          ts0_transp_i,
  input  logic [DW-1:0] rx_ts0_i,
  input  logic [DW-1:0] tx_ts0_i,
  output logic [DW-1:0] tx_ts0_o,
  input  logic          wr_en_i,
  input  logic [WR_W-1:0] wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [RD_W-1:0] rd_sel_i,
  output logic [DW-1:0] rd_data_o,
  input  logic [1:0]    irq_ack_i,
  output logic          rx_mb_irq_o,
  output logic          tx_mb_irq_o
);
  logic             mf_evt, svc_evt;
  logic [IDX_W-1:0] idx_q;
  logic [N_SW-1:0]  rx_sa   [N_SA];
  logic [N_SW-1:0]  tx_work [N_SA];
  logic [DW-1:0]    rx_sw, tx_sw;
  logic [1:0]       flags;

  assign mf_evt  = frame_stb_i & mf_start_i;
  assign svc_evt = frame_stb_i & svc_word_i & ~mf_start_i;

  // service-word position within the multiframe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (mf_evt)  idx_q <= '0;
    else if (svc_evt) idx_q <= (idx_q == IDX_W'(N_SW-1)) ? '0 : idx_q + 1'b1;
  end

  sa_rx_capture #(.SA_NUM(N_SA), .SW(N_SW), .BYTE_W(DW)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_en_i (svc_evt & mf_mode_i),
    .commit_i (mf_evt & mf_mode_i),
    .sw_en_i  (svc_evt & ~mf_mode_i),
    .idx_i    (idx_q),
    .byte_i   (rx_ts0_i),
    .sa_o     (rx_sa),
    .sw_o     (rx_sw)
  );

  sa_tx_insert #(.SA_NUM(N_SA), .SW(N_SW), .BYTE_W(DW), .WR_W(WR_W), .SEL_SW(SEL_SW)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .load_i    (mf_evt & mf_mode_i),
    .ins_en_i  (svc_evt & ~ts0_transp_i),
    .mf_mode_i (mf_mode_i),
    .idx_i     (idx_q),
    .byte_i    (tx_ts0_i),
    .byte_o    (tx_ts0_o),
    .work_o    (tx_work),
    .sw_o      (tx_sw)
  );

  sa_irq_flags #(.N(2)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({2{mf_evt & mf_mode_i}}),
    .ack_i  (irq_ack_i),
    .flag_o (flags)
  );

  assign rx_mb_irq_o = flags[0];
  assign tx_mb_irq_o = flags[1];

  always_comb begin
    rd_data_o = '0;
    for (int j = 0; j < N_SA; j++) begin
      if (rd_sel_i == RD_W'(j))             rd_data_o = DW'(rx_sa[j]);
      if (rd_sel_i == RD_W'(RD_TX_OFS + j)) rd_data_o = DW'(tx_work[j]);
    end
    if (rd_sel_i == RD_W'(SEL_SW))   rd_data_o = rx_sw;
    if (rd_sel_i == RD_W'(RD_TX_SW)) rd_data_o = tx_sw;
  end
endmodule

// File: rtl/sa_access_chk.sv
module sa_access_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_stb_i,
  input logic       svc_word_i,
  input logic       mf_start_i,
  input logic       mf_mode_i,
  input logic       ts0_transp_i,
  input logic [7:0] tx_ts0_i,
  input logic [7:0] tx_ts0_o,
  input logic [3:0] rd_sel_i,
  input logic [7:0] rd_data_o,
  input logic [1:0] irq_ack_i,
  input logic       rx_mb_irq_o,
  input logic       tx_mb_irq_o
);
  logic mf_set;
  assign mf_set = frame_stb_i && mf_start_i && mf_mode_i;

  AST_RX_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_set |=> rx_mb_irq_o); // R3
  AST_RX_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_mb_irq_o && !irq_ack_i[0]) |=> rx_mb_irq_o); // R3
  AST_RX_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i[0] && !mf_set) |=> !rx_mb_irq_o); // R3
  AST_TX_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_set |=> tx_mb_irq_o); // R4
  AST_TX_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i[1] && !mf_set) |=> !tx_mb_irq_o); // R4
  AST_FLAG_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mf_set && !rx_mb_irq_o) |=> !rx_mb_irq_o); // R10
  AST_RX_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mf_set && rd_sel_i < 4'd5) |=>
      (rd_sel_i != $past(rd_sel_i) || rd_data_o == $past(rd_data_o))); // R2
  AST_UPPER_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ts0_o[7:5] == tx_ts0_i[7:5]); // R5
  AST_TRANSP_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts0_transp_i |-> tx_ts0_o == tx_ts0_i); // R8
  AST_NON_SVC_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_stb_i && svc_word_i && !mf_start_i) |-> tx_ts0_o == tx_ts0_i); // R9
endmodule

bind sa_access sa_access_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_stb_i  (frame_stb_i),
  .svc_word_i   (svc_word_i),
  .mf_start_i   (mf_start_i),
  .mf_mode_i    (mf_mode_i),
  .ts0_transp_i (ts0_transp_i),
  .tx_ts0_i     (tx_ts0_i),
  .tx_ts0_o     (tx_ts0_o),
  .rd_sel_i     (rd_sel_i),
  .rd_data_o    (rd_data_o),
  .irq_ack_i    (irq_ack_i),
  .rx_mb_irq_o  (rx_mb_irq_o),
  .tx_mb_irq_o  (tx_mb_irq_o)
);

// File: tb/sim_sa_access.sv
`timescale 1ns/1ps
module sim_sa_access;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_stb = 0, svc = 0, mfs = 0, mf_mode = 0, transp = 0;
  logic [7:0] rx_b = 0, tx_b = 0, tx_o, wdata = 0, rdata;
  logic       wr_en = 0;
  logic [2:0] wsel = 0;
  logic [3:0] rsel = 0;
  logic [1:0] ack = 0;
  logic       rx_irq, tx_irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  sa_access u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_stb_i(frame_stb), .svc_word_i(svc),
    .mf_start_i(mfs), .mf_mode_i(mf_mode), .ts0_transp_i(transp),
    .rx_ts0_i(rx_b), .tx_ts0_i(tx_b), .tx_ts0_o(tx_o),
    .wr_en_i(wr_en), .wr_sel_i(wsel), .wr_data_i(wdata),
    .rd_sel_i(rsel), .rd_data_o(rdata), .irq_ack_i(ack),
    .rx_mb_irq_o(rx_irq), .tx_mb_irq_o(tx_irq)
  );

  // {rx Sa4..Sa8, tx Sa4..Sa8}, Sa4 in the top byte of each half
  localparam logic [79:0] VEC [4] = '{
    {40'h01_80_55_AA_FF, 40'h12_34_56_78_9A},
    {40'hC3_3C_0F_F0_81, 40'hFF_00_A5_5A_01},
    {40'h00_00_00_00_00, 40'h80_40_20_10_08},
    {40'hFE_7F_E7_18_99, 40'h00_FF_00_FF_00}
  };

  function automatic logic [7:0] sa(input logic [39:0] v, input int j);
    return v[39-8*j -: 8];
  endfunction

  // byte bits 4..0 = Sa4..Sa8 bit k
  function automatic logic [4:0] slot(input logic [39:0] v, input int k);
    logic [4:0] r;
    for (int j = 0; j < 5; j++) r[4-j] = sa(v, j)[k];
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] s, output logic [7:0] d);
    @(negedge clk); rsel = s; #2; d = rdata;
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wsel = s; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_ack(input logic [1:0] a);
    @(negedge clk); ack = a;
    @(negedge clk); ack = 0;
  endtask

  // one frame: strobe cycle, then one idle cycle; ends at the negedge after the strobe edge
  task automatic frm(input logic m, input logic s, input logic [7:0] rx, input logic [7:0] txi,
                     input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    frame_stb = 1; mfs = m; svc = s; rx_b = rx; tx_b = txi; ack = a;
    #5; chk(req, tx_o, exp);
    @(negedge clk);
    frame_stb = 0; mfs = 0; svc = 0; ack = 0;
  endtask

  // a multiframe after its start frame; optional mid write of Sa4
  task automatic mf_body(input logic [39:0] rxv, input logic [39:0] txexp, input bit mid_wr);
    logic [7:0] d;
    for (int f = 1; f < 16; f++) begin
      logic [7:0] ti;
      ti = 8'hC0 ^ 8'(f * 7);
      if (f[0]) begin
        frm(0, 1, {3'b011, slot(rxv, f/2)}, ti, 0, {ti[7:5], slot(txexp, f/2)}, "R5");
        if (mid_wr && f == 7) begin
          wr(0, 8'h5A);
          rd(8, d); chk("R7 working reg written at once", d, 8'h5A);
        end
      end else begin
        frm(0, 0, 8'hFF, ti, 0, ti, "R9");
      end
    end
  endtask

  task automatic check_rx(input logic [39:0] v, input string req);
    logic [7:0] d;
    for (int j = 0; j < 5; j++) begin
      rd(4'(j), d); chk(req, d, sa(v, j));
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, keep;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    for (int s = 0; s < 16; s++) begin
      rd(4'(s), d); chk("R11 reset read", d, 8'h00);
    end
    chk("R11 flags clear", {6'b0, tx_irq, rx_irq}, 8'h00);

    mf_mode = 1;
    for (int i = 0; i < 4; i++) begin
      logic [39:0] rxv, txv;
      rxv = VEC[i][79:40]; txv = VEC[i][39:0];
      for (int j = 0; j < 5; j++) wr(3'(j), sa(txv, j));
      for (int j = 0; j < 5; j++) begin
        rd(4'(8 + j), d); chk("R7 working readback", d, sa(txv, j));
      end
      frm(1, 0, 8'h00, 8'hA5, 0, 8'hA5, "R9 start frame passes");
      chk("R3 rx flag set", {7'b0, rx_irq}, 8'h01);
      chk("R4 tx flag set", {7'b0, tx_irq}, 8'h01);
      @(negedge clk);
      chk("R3 rx flag sticky", {7'b0, rx_irq}, 8'h01);
      do_ack(2'b01);
      chk("R3 rx flag cleared", {7'b0, rx_irq}, 8'h00);
      chk("R4 tx flag unaffected by rx ack", {7'b0, tx_irq}, 8'h01);
      do_ack(2'b10);
      chk("R4 tx flag cleared", {7'b0, tx_irq}, 8'h00);
      if (i > 0) check_rx(VEC[i-1][79:40], "R1 R2 rx Sa capture");
      mf_body(rxv, txv, 0);
      if (i > 0) check_rx(VEC[i-1][79:40], "R2 rx hold within multiframe");
    end

    // R6 repeat without rewrite; mid-multiframe write must not reach line (R7)
    frm(1, 0, 8'h00, 8'h3C, 2'b11, 8'h3C, "R9");
    chk("R3 set wins over ack", {6'b0, tx_irq, rx_irq}, 8'h03);
    do_ack(2'b11);
    check_rx(VEC[3][79:40], "R1 R2 last multiframe");
    mf_body(VEC[0][79:40], VEC[3][39:0], 1);
    // next multiframe carries the mid write on Sa4 only
    frm(1, 0, 8'h00, 8'h00, 2'b11, 8'h00, "R9");
    check_rx(VEC[0][79:40], "R1 R2 rx after repeat");
    mf_body(VEC[1][79:40], {8'h5A, VEC[3][31:0]}, 0);

    // R8 transparent mode
    transp = 1;
    frm(1, 0, 8'h00, 8'h11, 2'b11, 8'h11, "R8");
    frm(0, 1, 8'h00, 8'hE0, 0, 8'hE0, "R8 transparent svc word");
    frm(0, 1, 8'h00, 8'h0F, 0, 8'h0F, "R8 transparent svc word");
    transp = 0;
    // R9 svc high without strobe
    @(negedge clk); svc = 1; tx_b = 8'h9C; #5; chk("R9 no strobe", tx_o, 8'h9C);
    @(negedge clk); svc = 0;

    // R10 per-frame mode
    do_ack(2'b11);
    rd(0, keep);
    mf_mode = 0;
    wr(5, 8'h15);
    rd(13, d); chk("R10 tx per-frame readback", d, 8'h15);
    frm(0, 1, 8'hA7, 8'hE0, 0, 8'hF5, "R10 per-frame insert");
    rd(5, d); chk("R10 rx per-frame capture", d, 8'hA7);
    frm(1, 0, 8'h00, 8'h42, 0, 8'h42, "R10 start frame passes");
    chk("R10 no flag in per-frame mode", {6'b0, tx_irq, rx_irq}, 8'h00);
    frm(0, 1, 8'h3B, 8'h00, 0, 8'h15, "R10 per-frame repeat");
    rd(5, d); chk("R10 rx per-frame update", d, 8'h3B);
    rd(0, d); chk("R10 rx Sa4 unchanged", d, keep);
    rd(6, d); chk("R11 unassigned read", d, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule